// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one unsigned n-bit integer by another and returns the quotient and the remainder. It has one working register that holds the partial remainder and a second register that starts with the dividend and ends with the quotient. It produces one quotient bit per pair of clock cycles. In the first cycle of a pair, both registers shift left together as one wide register. In the second cycle, the block makes a trial subtraction of the stored divisor. If the result is not negative, the block writes it back. If it is negative, the block keeps the shifted value unchanged (restoring division). The new quotient bit goes into the low bit of the quotient register.

A caller pulses the start input while the block is idle, with the operands on its inputs. The block captures both operands on that edge. It then runs a fixed schedule of 2n further edges, with no early exit. It then raises its done flag, and from that point both registers stay frozen until the next accepted start. The partial remainder is one bit wider than the operands internally, so divisors that use the top bit are still compared correctly. Only the low n bits are reported.

Top module: `rdiv_seq`

## Requirements
- R1: After reset, busy_o and done_o are 0 and quotient_o and remainder_o are 0.
- R2: A start_i high at a clock edge while busy_o is 0 is accepted. From the next cycle, busy_o is 1 and done_o is 0.
- R3: Counting the accepting edge as edge 1, done_o rises at edge 2n+1 and busy_o falls at that same edge, so busy_o is high for exactly 2n cycles.
- R4: For a non-zero divisor, quotient_o equals dividend / divisor and remainder_o equals dividend mod divisor once done_o is 1, over the full unsigned range of both operands.
- R5: A zero divisor gives an all-ones quotient and a remainder equal to the dividend, within the same 2n+1-edge schedule.
- R6: While done_o is 1 and no start is accepted, done_o, quotient_o and remainder_o hold their values, whatever dividend_i and divisor_i do.
- R7: A start_i pulse while busy_o is 1 is ignored. The running division finishes on its own schedule with the operands it captured.
- R8: dividend_i and divisor_i are sampled only at the accepting edge. Changing them during a division does not alter its result.
- R9: If start_i is held high through completion, it is ignored at the completing edge. It is accepted one edge later, so done_o is 1 for exactly one cycle before the next division begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only when idle |
| dividend_i | input | WIDTH | Unsigned dividend |
| divisor_i | input | WIDTH | Unsigned divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | Result valid; held until next accepted start |
| quotient_o | output | WIDTH | Quotient |
| remainder_o | output | WIDTH | Remainder |

## Verification
Two events can fall in the same cycle: a new start request and the final trial-subtraction edge that completes a division. The bench provokes this by holding start_i high from the start of a run through its completion. It changes the operands just as done_o appears. It then judges three things: done_o is seen for exactly one cycle with the first result, busy_o rises on the following edge, and the second result matches the new operands. Start pulses placed in the middle of a run are judged by the result and the completion cycle, which must be those of the undisturbed division.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2,
    OP_TRIAL = 2'd3
  } rdiv_op_e;
endpackage

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  output rdiv_pkg::rdiv_op_e op_o,
  output logic               busy_o,
  output logic               done_o
);
  import rdiv_pkg::*;

  localparam int STEPS = 2 * WIDTH;
  localparam int CW    = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(STEPS - 1);

  logic [CW-1:0] step_q;
  logic          busy_q, done_q;
  logic          accept;

  assign accept = start_i & ~busy_q;

  // even steps shift, odd steps subtract and write back
  always_comb begin
    if (accept)      op_o = OP_LOAD;
    else if (busy_q) op_o = step_q[0] ? OP_TRIAL : OP_SHIFT;
    else             op_o = OP_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (accept) begin
      step_q <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      step_q <= step_q + 1'b1;
      if (step_q == LAST_STEP) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/rdiv_sub.sv
module rdiv_sub #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH:0]   a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH:0]   diff_o,
  output logic             neg_o
);
  // one guard bit above the widened remainder acts as the borrow
  assign {neg_o, diff_o} = {1'b0, a_i} - {2'b00, b_i};
endmodule

// File: rtl/rdiv_regs.sv
module rdiv_regs #(
  parameter int WIDTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  rdiv_pkg::rdiv_op_e op_i,
  input  logic [WIDTH-1:0]   dividend_i,
  input  logic [WIDTH-1:0]   divisor_i,
  input  logic [WIDTH:0]     diff_i,
  input  logic               neg_i,
  output logic [WIDTH:0]     rem_o,
  output logic [WIDTH-1:0]   quo_o,
  output logic [WIDTH-1:0]   dvs_o
);
  import rdiv_pkg::*;

  logic [WIDTH:0]   rem_q, rem_d;
  logic [WIDTH-1:0] quo_q, quo_d;
  logic [WIDTH-1:0] dvs_q, dvs_d;

  // remainder source select: zero, shifted, or subtractor
  always_comb begin
    rem_d = rem_q;
    quo_d = quo_q;
    dvs_d = dvs_q;
    unique case (op_i)
      OP_LOAD: begin
        rem_d = '0;
        quo_d = dividend_i;
        dvs_d = divisor_i;
      end
      OP_SHIFT: begin
        rem_d = {rem_q[WIDTH-1:0], quo_q[WIDTH-1]};
        quo_d = {quo_q[WIDTH-2:0], 1'b0};
      end
      OP_TRIAL: begin
        rem_d = neg_i ? rem_q : diff_i;
        quo_d = {quo_q[WIDTH-1:1], ~neg_i};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      dvs_q <= dvs_d;
    end
  end

  assign rem_o = rem_q;
  assign quo_o = quo_q;
  assign dvs_o = dvs_q;
endmodule

// File: rtl/rdiv_seq.sv
module rdiv_seq #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] quotient_o,
  output logic [WIDTH-1:0] remainder_o
);
  import rdiv_pkg::*;

  rdiv_op_e         op;
  logic [WIDTH:0]   rem, diff;
  logic [WIDTH-1:0] dvs;
  logic             neg;

  rdiv_ctrl #(.WIDTH(WIDTH)) i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .op_o   (op),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  rdiv_sub #(.WIDTH(WIDTH)) i_sub (
    .a_i   (rem),
    .b_i   (dvs),
    .diff_o(diff),
    .neg_o (neg)
  );

  rdiv_regs #(.WIDTH(WIDTH)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .dividend_i(dividend_i),
    .divisor_i (divisor_i),
    .diff_i    (diff),
    .neg_i     (neg),
    .rem_o     (rem),
    .quo_o     (quotient_o),
    .dvs_o     (dvs)
  );

  assign remainder_o = rem[WIDTH-1:0];
endmodule

// File: rtl/rdiv_checker.sv
module rdiv_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [WIDTH-1:0] divisor_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] quotient_o,
  input logic [WIDTH-1:0] remainder_o
);
  localparam int CW = $clog2(2 * WIDTH + 2);
  localparam logic [CW-1:0] RUN_LEN = CW'(2 * WIDTH);

  logic [CW-1:0]    busy_cnt;
  logic [WIDTH-1:0] dvs_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_cnt <= '0;
      dvs_seen <= '0;
    end else if (start_i && !busy_o) begin
      busy_cnt <= '0;
      dvs_seen <= divisor_i;
    end else if (busy_o) begin
      busy_cnt <= busy_cnt + 1'b1;
    end
  end

  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && !done_o);

  assert_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  assert_run_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> busy_cnt == RUN_LEN);

  assert_rem_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) && dvs_seen != '0 |-> remainder_o < dvs_seen);

  assert_zero_div_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) && dvs_seen == '0 |-> quotient_o == '1);

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && $stable(quotient_o) && $stable(remainder_o));
endmodule

bind rdiv_seq rdiv_checker #(.WIDTH(WIDTH)) i_rdiv_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .divisor_i  (divisor_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .quotient_o (quotient_o),
  .remainder_o(remainder_o)
);

// File: tb/test_rdiv_seq.sv
module test_rdiv_seq;
  localparam int W  = 8;
  localparam int NV = 12;
  localparam int RUN_EDGES = 2 * W + 1;

  // {dividend, divisor, quotient, remainder}
  localparam logic [31:0] VEC [NV] = '{
    {8'd100, 8'd7,   8'd14,  8'd2},
    {8'd255, 8'd1,   8'd255, 8'd0},
    {8'd255, 8'd255, 8'd1,   8'd0},
    {8'd0,   8'd5,   8'd0,   8'd0},
    {8'd200, 8'd201, 8'd0,   8'd200},
    {8'd128, 8'd3,   8'd42,  8'd2},
    {8'd250, 8'd16,  8'd15,  8'd10},
    {8'd77,  8'd0,   8'd255, 8'd77},
    {8'd1,   8'd128, 8'd0,   8'd1},
    {8'd254, 8'd127, 8'd2,   8'd0},
    {8'd199, 8'd13,  8'd15,  8'd4},
    {8'd255, 8'd128, 8'd1,   8'd127}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dvd = '0, dvs = '0;
  logic         busy, done;
  logic [W-1:0] quo, rem;
  int           checks = 0, fails = 0, wd = 0;

  always #4 clk = ~clk;

  rdiv_seq #(.WIDTH(W)) i_rdiv_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .dividend_i(dvd), .divisor_i(dvs),
    .busy_o(busy), .done_o(done), .quotient_o(quo), .remainder_o(rem)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      summary();
    end
  end

  // pulse start, return edges counted from the accepting edge until done
  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, output int cyc);
    @(negedge clk);
    start = 1'b1; dvd = a; dvs = b;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    chk(busy && !done, "R2", "busy/done after accept", {busy, done}, 2);
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic expect_result(input logic [W-1:0] a, input logic [W-1:0] b,
                               input string req);
    int eq, er;
    eq = (b == 0) ? (1 << W) - 1 : a / b;
    er = (b == 0) ? a : a % b;
    chk(quo == eq[W-1:0], req, "quotient", quo, eq);
    chk(rem == er[W-1:0], req, "remainder", rem, er);
  endtask

  initial begin
    int cyc;
    #3;
    chk(!busy && !done && quo == 0 && rem == 0, "R1", "reset state",
        {busy, done, quo, rem}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1", "idle after reset", {busy, done}, 0);

    // table of vectors (R4, R5 for zero divisor row)
    for (int i = 0; i < NV; i++) begin
      run(VEC[i][31:24], VEC[i][23:16], cyc);
      chk(cyc == RUN_EDGES, "R3", "edges to done", cyc, RUN_EDGES);
      chk(quo == VEC[i][15:8], (VEC[i][23:16] == 0) ? "R5" : "R4",
          "table quotient", quo, VEC[i][15:8]);
      chk(rem == VEC[i][7:0], (VEC[i][23:16] == 0) ? "R5" : "R4",
          "table remainder", rem, VEC[i][7:0]);
    end

    // swept operands against integer division
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] a, b;
      a = W'((i * 37 + 11) % 256);
      b = W'((i * 53 + 3) % 256);
      if (i == 7) b = '0;
      run(a, b, cyc);
      chk(cyc == RUN_EDGES, "R3", "sweep edges", cyc, RUN_EDGES);
      expect_result(a, b, (b == 0) ? "R5" : "R4");
    end

    // R6: hold while inputs wander
    run(8'd93, 8'd10, cyc);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      dvd = W'(k * 41); dvs = W'(k * 7 + 1);
    end
    chk(done && !busy, "R6", "done held", {busy, done}, 1);
    expect_result(8'd93, 8'd10, "R6");

    // R7 and R8: start pulses and operand changes mid-run
    @(negedge clk);
    start = 1'b1; dvd = 8'd211; dvs = 8'd9;
    @(negedge clk);
    start = 1'b0; dvd = 8'd3; dvs = 8'd1;
    cyc = 1;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (cyc == 5 || cyc == RUN_EDGES - 1) start = 1'b1;
      else start = 1'b0;
      dvd = W'(cyc * 13); dvs = W'(cyc);
    end
    start = 1'b0;
    chk(cyc == RUN_EDGES, "R7", "edges with stray starts", cyc, RUN_EDGES);
    expect_result(8'd211, 8'd9, "R8");

    // R9: start held through completion
    @(negedge clk);
    start = 1'b1; dvd = 8'd180; dvs = 8'd11;
    @(negedge clk);
    cyc = 1;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == RUN_EDGES, "R9", "first run edges", cyc, RUN_EDGES);
    expect_result(8'd180, 8'd11, "R9");
    dvd = 8'd66; dvs = 8'd5;
    @(negedge clk);
    chk(busy && !done, "R9", "restart one edge after done", {busy, done}, 2);
    start = 1'b0;
    cyc = 2;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == RUN_EDGES + 1, "R9", "second run edges", cyc - 1, RUN_EDGES);
    expect_result(8'd66, 8'd5, "R9");

    summary();
  end
endmodule